// File: doc/BRIEF.md
# Serial Control-Port Master for an Audio Receiver

This block drives the serial control port of an audio receiver device. The port has four wires: an active-low chip select, a serial clock, a write-data line and a read-data line. The block turns single register accesses into framed bit sequences on those wires. A host raises a request together with the device address, a register pointer and, for a write, one data byte. The block drops chip select, shifts the bytes out at a slow, fixed bit rate, raises chip select again, and signals completion. A typical device address is 0x20.

A write is a single frame of three bytes. A read uses two frames, because the device keeps the register pointer between frames. The first frame sends the address in write form followed by the pointer. The second frame sends the address with its read flag set and then clocks in one byte. Each bit is made of three phases of equal length. In the first phase the clock is low. In the second phase the clock stays low and the data line is updated. In the third phase the clock is high. The parameter `PHASE_CYC` sets the phase length in system clocks; the default of 125 gives about one microsecond at 125 MHz.

Top module: `spi_ctl_master`

## Requirements
- R1: After reset, chip select and the serial clock are both high, and busy and done are both low.
- R2: A write produces exactly one chip-select-low frame of 24 clock pulses, sent MSB first. The frame carries the address with bit 0 forced to 0, then the register pointer, then the data byte.
- R3: Inside a frame, every bit holds the clock low for 2 phases and then high for 1 phase. The write-data line changes only at the boundary between the two low phases, and it is stable while the clock is high.
- R4: A read produces two frames of 16 clock pulses each. The first frame carries the address with bit 0 forced to 0, then the pointer. The second frame starts with the address with bit 0 forced to 1.
- R5: In the last 8 bits of the second read frame, the read-data line is sampled at the end of the first low phase of each bit. The first bit sampled becomes bit 7 of the returned byte.
- R6: After each frame, chip select stays high for one phase before the next frame starts or before done is raised. The write latency from the accepting clock edge to done is 73 phases, and the read latency is 98 phases.
- R7: A request is accepted only while busy is low. A request raised while a transfer is running has no effect. A request present in the same cycle as done is accepted on the next edge.
- R8: Done is high for exactly one cycle, busy is low in that cycle, and for a read the returned byte is valid in that cycle.
- R9: The serial clock is high whenever chip select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Start request, sampled while idle |
| rd_i | input | 1 | 1 = read access, 0 = write access |
| chip_addr_i | input | 8 | Device address; bit 0 is replaced by the block |
| map_i | input | 8 | Register pointer |
| wdata_i | input | 8 | Write data byte |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 8 | Byte returned by a read |
| cs_no | output | 1 | Chip select, active low |
| sclk_o | output | 1 | Serial clock, idles high |
| mosi_o | output | 1 | Serial write data |
| miso_i | input | 1 | Serial read data |

## Verification
Completion of one transfer and acceptance of the next can fall in the same cycle. A host that holds its request through the done pulse must have that request taken on the following edge, and the done pulse must not be stretched. The bench provokes this by raising a new request in the cycle where done is seen. It then checks three things: done falls after one cycle, busy rises at the next edge, and the repeated transfer produces correct frames and the correct latency. A second stimulus raises a request in the middle of a transfer. The bench checks that no extra frame appears and that busy stays low after completion.

// File: rtl/spi_ctl_pkg.sv
package spi_ctl_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_SHIFT, ST_GAP} st_e;
  typedef enum logic [1:0] {PH_LOW, PH_SET, PH_HIGH} ph_e;
endpackage

// File: rtl/spi_ctl_timer.sv
module spi_ctl_timer #(
  parameter int PHASE_CYC = 125
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic clr_i,
  output logic tick_o
);
  localparam int CW = $clog2(PHASE_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(PHASE_CYC - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (run_i)  cnt_q <= tick_o ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/spi_ctl_rx.sv
module spi_ctl_rx #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         shift_i,
  input  logic         bit_i,
  output logic [W-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      data_o <= '0;
    else if (shift_i) data_o <= {data_o[W-2:0], bit_i};
  end
endmodule

// File: rtl/spi_ctl_master.sv
module spi_ctl_master
  import spi_ctl_pkg::*;
#(
  parameter int PHASE_CYC = 125,
  parameter int BYTE_W    = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              rd_i,
  input  logic [BYTE_W-1:0] chip_addr_i,
  input  logic [BYTE_W-1:0] map_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [BYTE_W-1:0] rdata_o,
  output logic              cs_no,
  output logic              sclk_o,
  output logic              mosi_o,
  input  logic              miso_i
);
  localparam int FRAME_W = 3 * BYTE_W;
  localparam int SHORT_W = 2 * BYTE_W;
  localparam int BCNT_W  = $clog2(FRAME_W + 1);

  st_e                st_q;
  ph_e                ph_q;
  logic [FRAME_W-1:0] sr_q;
  logic [BCNT_W-1:0]  left_q;
  logic               rd_q, second_q;
  logic [BYTE_W-1:0]  addr_q;
  logic [BYTE_W-1:0]  rx_data;
  logic               tick, accept, in_bit, rx_shift;

  assign accept   = (st_q == ST_IDLE) && req_i;
  assign in_bit   = second_q && (left_q <= BCNT_W'(BYTE_W));
  assign rx_shift = tick && (st_q == ST_SHIFT) && (ph_q == PH_LOW) && in_bit;
  assign busy_o   = (st_q != ST_IDLE);

  spi_ctl_timer #(.PHASE_CYC(PHASE_CYC)) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (busy_o),
    .clr_i (accept),
    .tick_o(tick)
  );

  spi_ctl_rx #(.W(BYTE_W)) u_rx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .shift_i(rx_shift),
    .bit_i  (miso_i),
    .data_o (rx_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      ph_q     <= PH_LOW;
      sr_q     <= '0;
      left_q   <= '0;
      rd_q     <= 1'b0;
      second_q <= 1'b0;
      addr_q   <= '0;
      cs_no    <= 1'b1;
      sclk_o   <= 1'b1;
      mosi_o   <= 1'b0;
      done_o   <= 1'b0;
      rdata_o  <= '0;
    end else begin
      done_o <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (req_i) begin
          st_q     <= ST_SHIFT;
          ph_q     <= PH_LOW;
          cs_no    <= 1'b0;
          sclk_o   <= 1'b0;
          rd_q     <= rd_i;
          second_q <= 1'b0;
          addr_q   <= chip_addr_i;
          if (rd_i) begin
            sr_q   <= {chip_addr_i[BYTE_W-1:1], 1'b0, map_i, {BYTE_W{1'b0}}};
            left_q <= BCNT_W'(SHORT_W);
          end else begin
            sr_q   <= {chip_addr_i[BYTE_W-1:1], 1'b0, map_i, wdata_i};
            left_q <= BCNT_W'(FRAME_W);
          end
        end
        ST_SHIFT: if (tick) begin
          unique case (ph_q)
            PH_LOW: begin
              ph_q <= PH_SET;
              if (!in_bit) begin
                mosi_o <= sr_q[FRAME_W-1];
                sr_q   <= sr_q << 1;
              end
            end
            PH_SET: begin
              sclk_o <= 1'b1;
              ph_q   <= PH_HIGH;
            end
            default: begin
              left_q <= left_q - 1'b1;
              if (left_q == BCNT_W'(1)) begin
                st_q  <= ST_GAP;
                cs_no <= 1'b1;
              end else begin
                ph_q   <= PH_LOW;
                sclk_o <= 1'b0;
              end
            end
          endcase
        end
        ST_GAP: if (tick) begin
          if (rd_q && !second_q) begin
            // second frame: address with read flag, then capture
            second_q <= 1'b1;
            st_q     <= ST_SHIFT;
            ph_q     <= PH_LOW;
            cs_no    <= 1'b0;
            sclk_o   <= 1'b0;
            sr_q     <= {addr_q[BYTE_W-1:1], 1'b1, {SHORT_W{1'b0}}};
            left_q   <= BCNT_W'(SHORT_W);
          end else begin
            st_q   <= ST_IDLE;
            done_o <= 1'b1;
            if (rd_q) rdata_o <= rx_data;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_ctl_master_chk.sv
module spi_ctl_master_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic req_i,
  input logic busy_o,
  input logic done_o,
  input logic cs_no,
  input logic sclk_o,
  input logic mosi_o
);
  // R3
  mosi_stable_hi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_o && $past(sclk_o) && !cs_no) |-> $stable(mosi_o));

  // R9
  cs_idle_clk_hi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> sclk_o);

  // R8
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R8
  done_not_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  // R7
  accept_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(req_i));
endmodule

bind spi_ctl_master spi_ctl_master_chk u_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .req_i (req_i),
  .busy_o(busy_o),
  .done_o(done_o),
  .cs_no (cs_no),
  .sclk_o(sclk_o),
  .mosi_o(mosi_o)
);

// File: tb/spi_ctl_master_tb.sv
`timescale 1ns/1ps
module spi_ctl_master_tb;
  localparam int P = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, rd = 1'b0;
  logic [7:0] addr = '0, map = '0, wd = '0;
  logic busy, done, cs_n, sclk, mosi;
  logic [7:0] rdata;
  logic miso = 1'b0;

  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  spi_ctl_master #(.PHASE_CYC(P), .BYTE_W(8)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .rd_i(rd),
    .chip_addr_i(addr), .map_i(map), .wdata_i(wd),
    .busy_o(busy), .done_o(done), .rdata_o(rdata),
    .cs_no(cs_n), .sclk_o(sclk), .mosi_o(mosi), .miso_i(miso)
  );

  // device model
  int nb = 0;
  int fcount = 0;
  logic [23:0] sh = '0;
  logic [23:0] fr_val [0:7];
  int fr_len [0:7];
  logic [7:0] rbyte = '0;

  always @(negedge cs_n) begin nb = 0; sh = '0; end
  always @(posedge sclk) if (cs_n === 1'b0) begin sh = {sh[22:0], mosi}; nb++; end
  always @(posedge cs_n) if (nb > 0) begin
    fr_val[fcount % 8] = sh; fr_len[fcount % 8] = nb; fcount++; nb = 0;
  end
  always @(negedge sclk) if (cs_n === 1'b0 && nb >= 8 && nb < 16) miso = rbyte[15 - nb];

  // bit timing monitor
  int terr = 0, run = 0;
  logic p_sclk = 1'b1, p_mosi = 1'b0, p_cs = 1'b1;
  always @(negedge clk) if (rst_n) begin
    if (sclk !== p_sclk) begin
      if (!cs_n && sclk && run != 2*P) terr++;
      if (!cs_n && !p_cs && !sclk && run != P) terr++;
      run = 1;
    end else run++;
    if (mosi !== p_mosi && !cs_n && (sclk || run != P + 1)) terr++;
    p_sclk = sclk; p_mosi = mosi; p_cs = cs_n;
  end

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", what, act, exp);
    end
  endtask

  task automatic do_xfer(input bit r, input logic [7:0] a, input logic [7:0] m,
                         input logic [7:0] w, input logic [7:0] rb,
                         input bit poke, input bit chained, input bit chain_next);
    int fs, te, n, exp_n, i0, i1;
    fs = fcount; te = terr; rbyte = rb;
    if (!chained) begin
      @(negedge clk);
      rd = r; addr = a; map = m; wd = w; req = 1'b1;
      @(posedge clk); #1; req = 1'b0;
    end
    chk(busy == 1'b1, "R7 busy after accept", busy, 1);
    n = 0;
    while (1) begin
      @(posedge clk); #1; n++;
      if (poke && n == 20) begin addr = ~a; rd = ~r; req = 1'b1; end
      if (poke && n == 21) begin req = 1'b0; addr = a; rd = r; end
      if (done || n > 100000) break;
    end
    exp_n = (r ? 98 : 73) * P;
    chk(n == exp_n, "R6/R8 latency", n, exp_n);
    chk(busy == 1'b0, "R8 busy low with done", busy, 0);
    if (r) chk(rdata == rb, "R5 read byte", rdata, rb);
    i0 = fs % 8; i1 = (fs + 1) % 8;
    if (!r) begin
      chk(fcount - fs == 1, "R2 frame count", fcount - fs, 1);
      chk(fr_len[i0] == 24, "R2 frame bits", fr_len[i0], 24);
      chk(fr_val[i0] == {a[7:1], 1'b0, m, w}, "R2 frame value", fr_val[i0], {a[7:1], 1'b0, m, w});
    end else begin
      chk(fcount - fs == 2, "R4 frame count", fcount - fs, 2);
      chk(fr_len[i0] == 16 && fr_len[i1] == 16, "R4 frame bits", {fr_len[i0][15:0], fr_len[i1][15:0]}, 32'h0010_0010);
      chk(fr_val[i0][15:0] == {a[7:1], 1'b0, m}, "R4 pointer frame", fr_val[i0][15:0], {a[7:1], 1'b0, m});
      chk(fr_val[i1][15:8] == {a[7:1], 1'b1}, "R4 read address", fr_val[i1][15:8], {a[7:1], 1'b1});
    end
    chk(terr == te, "R3 bit timing", terr - te, 0);
    chk(cs_n == 1'b1 && sclk == 1'b1, "R9 idle lines", {cs_n, sclk}, 2'b11);
    if (chain_next) begin
      req = 1'b1;
      @(posedge clk); #1; req = 1'b0;
      chk(done == 1'b0, "R8 done one cycle", done, 0);
    end else begin
      @(posedge clk); #1;
      chk(done == 1'b0, "R8 done one cycle", done, 0);
      chk(busy == 1'b0, "R7 no extra start", busy, 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired act=1 exp=0");
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] ra, rm, rw, rr;
    bit rdr;
    void'($urandom(32'd4321));
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk(cs_n == 1'b1 && sclk == 1'b1, "R1 lines in reset", {cs_n, sclk}, 2'b11);
    chk(busy == 1'b0 && done == 1'b0, "R1 status in reset", {busy, done}, 2'b00);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(cs_n == 1'b1 && sclk == 1'b1 && !busy, "R1 after reset", {cs_n, sclk, busy}, 3'b110);

    do_xfer(1'b0, 8'h20, 8'h04, 8'h80, 8'h00, 1'b0, 1'b0, 1'b0);
    do_xfer(1'b0, 8'h21, 8'hFF, 8'h01, 8'h00, 1'b0, 1'b0, 1'b0);
    do_xfer(1'b1, 8'h20, 8'h7F, 8'h00, 8'hA5, 1'b0, 1'b0, 1'b0);
    do_xfer(1'b1, 8'h21, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0);
    do_xfer(1'b1, 8'h20, 8'h26, 8'h00, 8'hFF, 1'b0, 1'b0, 1'b0);
    // R7 request during a transfer is ignored
    do_xfer(1'b0, 8'h20, 8'h05, 8'h05, 8'h00, 1'b1, 1'b0, 1'b0);
    // R7 request in the done cycle: back-to-back transfers
    do_xfer(1'b1, 8'h20, 8'h13, 8'h00, 8'h3C, 1'b0, 1'b0, 1'b1);
    do_xfer(1'b1, 8'h20, 8'h13, 8'h00, 8'hC3, 1'b0, 1'b1, 1'b1);
    do_xfer(1'b1, 8'h20, 8'h13, 8'h00, 8'h5A, 1'b0, 1'b1, 1'b0);

    for (int k = 0; k < 30; k++) begin
      rdr = 1'($urandom);
      ra = 8'($urandom); rm = 8'($urandom); rw = 8'($urandom); rr = 8'($urandom);
      do_xfer(rdr, ra, rm, rw, rr, 1'b0, 1'b0, 1'b0);
    end

    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule